// File: doc/BRIEF.md
# Two-Wire Register Write Slave

This block is the write-only target side of a two-wire serial control bus. A system clock oversamples the clock line (SCL) and data line (SDA). Both lines pass through synchronizers and a glitch filter before the block looks for start and stop conditions. After a start, the block collects an 8-bit header: a 7-bit device address, MSB first, then a direction bit. It takes part in the transfer only when the address equals its own and the direction bit asks for a write.

Once selected, the block acknowledges the header. It then takes a register address byte, followed by any number of data bytes, and acknowledges each of them. For every data byte it gives the register file behind it a one-cycle write strobe, together with an address and a data value. The address steps by one after each data byte, so a burst fills consecutive registers.

On an address mismatch or a read request, the block goes back to idle. It also goes back to idle on a stop condition at any point. It then ignores the bus until the next start. A start seen in the middle of a frame begins a new header.

Top module: `tw_reg_write_slave`

## Requirements
- R1: After reset, the SDA drive enable, the write strobe, the register address output and the write data output are all 0.
- R2: A start condition (SDA falling while SCL is high) begins a new header from any state. When the 7 header address bits, sent MSB first, equal DEV_ADDR and the 8th bit is 0, `sda_drive_o` is 1 (SDA pulled low) during the 9th SCL clock.
- R3: When the header address differs from DEV_ADDR, or the direction bit is 1, the 9th clock is not acknowledged. All later bytes are neither acknowledged nor written until the next start.
- R4: In a selected frame, the byte after the header is taken as the register address and is acknowledged on its 9th clock.
- R5: Each following byte is data, received MSB first, and is acknowledged. After the falling SCL that ends its acknowledge clock, `reg_wr_o` is high for exactly one system clock. At that time `reg_data_o` holds the byte and `reg_addr_o` holds the target register address.
- R6: The first data byte of a frame goes to the register address received in R4. Each later data byte goes to the previous address plus one, modulo 2^REG_AW (0xFF is followed by 0x00).
- R7: A stop condition (SDA rising while SCL is high) returns the block to idle from any state. A partly received data byte is discarded. Bytes clocked after the stop without a new start are neither acknowledged nor written.
- R8: A repeated start in the middle of a data byte abandons that byte and begins a new header. Bytes already completed keep their writes.
- R9: `sda_drive_o` changes only while the filtered SCL is low.
- R10: A pulse on SCL or SDA lasting fewer than FILT_LEN system clocks has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_addr_o | output | REG_AW | Register address of the current write |
| reg_data_o | output | 8 | Write data byte |
| reg_wr_o | output | 1 | One-cycle write strobe |

## Verification
A wrong bit counter or shift register shows up within a single byte: the acknowledge moves to the wrong clock, or a written value has its bits shifted. A stuck or misplaced state gives a missing or extra acknowledge on the very next 9th clock. It also gives strobes where none should be, for example after a mismatch or a stop. A wrong address pointer is visible on the second write of a burst, and its wrap at 0xFF shows within three bytes. A filter that is too weak turns a one-clock SCL glitch into an extra bit, which corrupts the data of that same byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_REG,
    S_REG_ACK,
    S_DAT,
    S_DAT_ACK
  } tw_state_t;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  // Synchronizer chain; idle bus level is high.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // Output follows only once FILT_LEN consecutive samples agree.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tw_write_fsm.sv
module tw_write_fsm
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int         REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              sda_drive_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_data_o,
  output logic              reg_wr_o
);
  tw_state_t          st;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  shreg;
  logic [BYTE_W-1:0]  dat_hold;
  logic [REG_AW-1:0]  ptr;
  logic               byte_done;
  logic               shifting;

  assign shifting  = (st == S_DEV) || (st == S_REG) || (st == S_DAT);
  assign byte_done = shifting && scl_fall && (bit_cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      dat_hold    <= '0;
      ptr         <= '0;
      sda_drive_o <= 1'b0;
      reg_addr_o  <= '0;
      reg_data_o  <= '0;
      reg_wr_o    <= 1'b0;
    end else begin
      reg_wr_o <= 1'b0;
      if (stop_evt) begin
        st          <= S_IDLE;
        bit_cnt     <= '0;
        sda_drive_o <= 1'b0;
      end else if (start_evt) begin
        st          <= S_DEV;
        bit_cnt     <= '0;
        sda_drive_o <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_REG, S_DAT: begin
            if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              if (st == S_DEV) begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR && !shreg[0]) begin
                  sda_drive_o <= 1'b1;
                  st          <= S_DEV_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_REG) begin
                ptr         <= REG_AW'(shreg);
                sda_drive_o <= 1'b1;
                st          <= S_REG_ACK;
              end else begin
                dat_hold    <= shreg;
                sda_drive_o <= 1'b1;
                st          <= S_DAT_ACK;
              end
            end
          end
          S_DEV_ACK, S_REG_ACK: begin
            if (scl_fall) begin
              sda_drive_o <= 1'b0;
              bit_cnt     <= '0;
              st          <= (st == S_DEV_ACK) ? S_REG : S_DAT;
            end
          end
          S_DAT_ACK: begin
            if (scl_fall) begin
              sda_drive_o <= 1'b0;
              bit_cnt     <= '0;
              reg_wr_o    <= 1'b1;
              reg_addr_o  <= ptr;
              reg_data_o  <= dat_hold;
              ptr         <= ptr + 1'b1;
              st          <= S_DAT;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5: strobe is a single system clock wide
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  // R5: strobe follows a cycle in which the acknowledge was being driven
  a_r5_strobe_after_ack: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> $past(sda_drive_o));

  // R9: the drive enable moves only while the filtered clock is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_drive_o != $past(sda_drive_o)) |-> !scl_f);

  // R7: a stop leaves the line released and the block idle
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!sda_drive_o && st == S_IDLE));

  // R3: a read request is never acknowledged
  a_r3_no_ack_on_read: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEV && byte_done && shreg[0] && !start_evt && !stop_evt) |=> !sda_drive_o);
endmodule

// File: rtl/tw_reg_write_slave.sv
module tw_reg_write_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h1A,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         REG_AW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_data_o,
  output logic              reg_wr_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] flt_lines;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    tw_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  tw_bus_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (flt_lines[0]),
    .sda_f    (flt_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  tw_write_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .REG_AW  (REG_AW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_f      (flt_lines[0]),
    .sda_f      (flt_lines[1]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_drive_o(sda_drive_o),
    .reg_addr_o (reg_addr_o),
    .reg_data_o (reg_data_o),
    .reg_wr_o   (reg_wr_o)
  );
endmodule

// File: tb/tb_tw_reg_write_slave.sv
module tb_tw_reg_write_slave;
  localparam logic [6:0] DEV = 7'h1A;
  localparam int H = 16;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_o, reg_wr_o;
  logic [7:0] reg_addr_o, reg_data_o;
  wire  sda_bus = sda_m & ~sda_drive_o;

  int vectors = 0;
  int fails = 0;
  int wn = 0;
  int r9_viol = 0;
  bit done = 1'b0;
  logic [7:0] log_a [0:511];
  logic [7:0] log_d [0:511];
  logic drv_prev = 1'b0;

  always #10 clk = ~clk;

  tw_reg_write_slave #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_o(sda_drive_o), .reg_addr_o(reg_addr_o),
    .reg_data_o(reg_data_o), .reg_wr_o(reg_wr_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr_o) begin
        log_a[wn] = reg_addr_o;
        log_d[wn] = reg_data_o;
        wn = wn + 1;
      end
      if (sda_drive_o != drv_prev && scl_m) r9_viol = r9_viol + 1;
    end
    drv_prev = sda_drive_o;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    wait_clk(Q); sda_m = 1'b1;
    wait_clk(Q); scl_m = 1'b1;
    wait_clk(H); sda_m = 1'b0;
    wait_clk(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(Q); sda_m = 1'b0;
    wait_clk(Q); scl_m = 1'b1;
    wait_clk(H); sda_m = 1'b1;
    wait_clk(H);
    wait_clk(20);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      wait_clk(Q); sda_m = b[i];
      if (glitch) begin
        wait_clk(4); scl_m = 1'b1; wait_clk(1); scl_m = 1'b0; wait_clk(Q - 5);
      end else begin
        wait_clk(Q);
      end
      scl_m = 1'b1; wait_clk(H); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    wait_clk(Q); sda_m = 1'b1;
    wait_clk(Q); scl_m = 1'b1;
    wait_clk(Q); ack = !sda_bus;
    wait_clk(Q); scl_m = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    int base;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    chk("R1 drive", sda_drive_o, 0);
    chk("R1 strobe", reg_wr_o, 0);
    chk("R1 addr", reg_addr_o, 0);
    chk("R1 data", reg_data_o, 0);

    // R2 / R3: sweep every device address with a write header
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, 1'b0, ack);
      chk((a == DEV) ? "R2 ack on match" : "R3 no ack on mismatch", ack, (a == DEV));
      bus_stop();
    end
    chk("R3 no writes during sweep", wn, 0);

    // R3: read request is refused, later bytes ignored
    bus_start();
    send_byte({DEV, 1'b1}, 1'b0, ack);
    chk("R3 read refused", ack, 0);
    send_byte(8'h10, 1'b0, ack);
    chk("R3 byte after read ignored", ack, 0);
    send_byte(8'h55, 1'b0, ack);
    chk("R3 data after read ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, ack);
    send_byte(8'h10, 1'b0, ack);
    chk("R3 byte after mismatch ignored", ack, 0);
    bus_stop();
    chk("R3 no writes", wn, 0);

    // R4 / R5: single write
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h20, 1'b0, ack);
    chk("R4 reg addr ack", ack, 1);
    send_byte(8'hA5, 1'b0, ack);
    chk("R5 data ack", ack, 1);
    bus_stop();
    chk("R5 write count", wn, 1);
    chk("R5 write addr", log_a[0], 8'h20);
    chk("R5 write data", log_d[0], 8'hA5);

    // R5 / R6: 256-byte burst over every data value
    base = wn;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    for (int i = 0; i < 256; i++) begin
      send_byte(8'(i) ^ 8'h3C, 1'b0, ack);
      chk("R5 burst ack", ack, 1);
    end
    bus_stop();
    chk("R6 burst count", wn - base, 256);
    for (int i = 0; i < 256; i++) begin
      chk("R6 burst addr", log_a[base + i], i);
      chk("R5 burst data", log_d[base + i], (i ^ 8'h3C) & 8'hFF);
    end

    // R6: wrap from 0xFE
    base = wn;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'hFE, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    send_byte(8'h02, 1'b0, ack);
    send_byte(8'h03, 1'b0, ack);
    bus_stop();
    chk("R6 wrap count", wn - base, 3);
    chk("R6 addr FE", log_a[base], 8'hFE);
    chk("R6 addr FF", log_a[base + 1], 8'hFF);
    chk("R6 addr wraps to 00", log_a[base + 2], 8'h00);
    chk("R6 data at 00", log_d[base + 2], 8'h03);

    // R7: stop in the middle of a data byte
    base = wn;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h40, 1'b0, ack);
    send_byte(8'h11, 1'b0, ack);
    send_bits(8'hF0, 4, 1'b0);
    bus_stop();
    chk("R7 partial byte discarded", wn - base, 1);
    chk("R7 kept addr", log_a[base], 8'h40);
    send_byte(8'h00, 1'b0, ack);
    chk("R7 no ack after stop", ack, 0);
    bus_stop();
    chk("R7 no write after stop", wn - base, 1);

    // R8: repeated start mid data byte
    base = wn;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h50, 1'b0, ack);
    send_byte(8'h77, 1'b0, ack);
    send_bits(8'hFF, 3, 1'b0);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    chk("R8 header ack after restart", ack, 1);
    send_byte(8'h60, 1'b0, ack);
    send_byte(8'h88, 1'b0, ack);
    bus_stop();
    chk("R8 write count", wn - base, 2);
    chk("R8 first addr", log_a[base], 8'h50);
    chk("R8 second addr", log_a[base + 1], 8'h60);
    chk("R8 second data", log_d[base + 1], 8'h88);

    // R10: one-clock SCL glitch in every bit of a data byte
    base = wn;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h70, 1'b0, ack);
    send_byte(8'h5A, 1'b1, ack);
    chk("R10 ack despite glitches", ack, 1);
    bus_stop();
    chk("R10 write count", wn - base, 1);
    chk("R10 data intact", log_d[base], 8'h5A);
    chk("R10 addr intact", log_a[base], 8'h70);

    // R9: drive never moved while SCL was high
    chk("R9 drive changes with SCL high", r9_viol, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule